// File: doc/BRIEF.md
# Phase-Accumulator Tone Oscillator

This block is the tone source of one synthesizer voice. A 24-bit phase accumulator advances by a 16-bit frequency word on every clock. Three basic 12-bit waveforms are formed from the phase: a ramp (sawtooth), a folded ramp (triangle) and a rectangle (pulse) whose duty is set by a 12-bit width. Software programs the voice through one byte-wide write port that selects one of five registers: two frequency bytes, two pulse-width bytes and a control byte.

The control byte picks the waveforms. When more than one is picked, they are bit-wise ANDed. The same byte also holds a test bit that parks the phase at zero, a ring bit that lets a neighbouring voice flip the triangle fold, and a sync bit that lets a neighbouring voice restart this phase. Both neighbour signals enter as single-bit inputs, normally the phase MSB of the adjacent voice. The running phase is also brought out so that it can feed those inputs on other voices.

A chip reset clears all programmed registers but leaves the phase where it is. The phase powers up holding alternating ones and zeros.

Top module: `tone_osc`

## Requirements
- R1: While `rst` is high on a clock edge, the frequency, pulse width and control registers clear to zero. After reset, with no writes, `acc_out` stays constant and `wave_out` is 0.
- R2: `acc_out` powers up as 0x555555. Cycles with `rst` high leave it unchanged.
- R3: With test and sync inactive, each clock edge with `rst` low adds the 16-bit frequency, zero-extended, to the accumulator modulo 2^24. A write to a frequency byte takes effect from the next edge.
- R4: Writes are selected by `wr_sel`: 0 is the frequency low byte, 1 the frequency high byte, 2 the pulse-width low byte, 3 the pulse-width high byte (only bits 3:0 kept), and 4 the control byte. Control bit 7 selects noise, 6 pulse, 5 sawtooth, 4 triangle, 3 is test, 2 is ring and 1 is sync. Bit 0 is stored but has no effect.
- R5: The sawtooth value is accumulator bits 23:12.
- R6: The triangle value is bits 22:12 of the accumulator, inverted when the fold bit is 1, followed by a 0 LSB. The fold bit is accumulator bit 23.
- R7: The pulse value is 0xFFF when accumulator bits 23:12 are at least the 12-bit pulse width, and 0 otherwise. It is re-evaluated at once when either pulse-width byte is written.
- R8: The accumulator reads 0 right after the edge that writes a control byte with test set, and stays 0 while test stays set. While test is set, the pulse value is 0xFFF.
- R9: With ring set and sawtooth not selected, the triangle fold bit is accumulator bit 23 XOR `ring_src`. When sawtooth is selected, `ring_src` has no effect.
- R10: With sync set, a clock edge at which `sync_src` is 1 after being 0 at the previous edge clears the accumulator to 0. With sync clear, `sync_src` has no effect.
- R11: `wave_out` is the AND of the selected sawtooth, triangle and pulse values. It is 0 when none of the three is selected. The noise select bit has no effect on `wave_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data byte |
| ring_src | input | 1 | Ring-modulation bit from the neighbouring voice |
| sync_src | input | 1 | Sync source bit from the neighbouring voice |
| acc_out | output | 24 | Current phase accumulator |
| wave_out | output | 12 | Waveform output |

## Verification
Assertions check on every cycle that the phase advances by the frequency when nothing interferes, and that a test write or a sync hit leaves it at zero on the next cycle. They also check that a selected triangle always has a zero LSB, that the output is zero with no waveform selected, and that a lone pulse under test is full scale. The bench scenarios are needed for the rest: the power-up pattern and its survival through reset, wrap-around of the phase, the immediate re-comparison on pulse-width writes, the masking of the pulse-width upper nibble, and the cases where the ring or sync inputs must be ignored.

// File: rtl/tone_osc_pkg.sv
package tone_osc_pkg;

    localparam int ACC_W  = 24;
    localparam int FREQ_W = 16;
    localparam int PW_W   = 12;
    localparam int OUT_W  = 12;
    localparam int BYTE_W = 8;

    localparam logic [ACC_W-1:0] ACC_POWERUP = 24'h555555;

    typedef enum logic [2:0] {
        SEL_FREQ_LO = 3'd0,
        SEL_FREQ_HI = 3'd1,
        SEL_PW_LO   = 3'd2,
        SEL_PW_HI   = 3'd3,
        SEL_CTRL    = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic noise_sel;
        logic pulse_sel;
        logic saw_sel;
        logic tri_sel;
        logic test;
        logic ring;
        logic sync;
        logic spare;
    } ctrl_t;

    function automatic logic [OUT_W-1:0] tri_fold(input logic [ACC_W-1:0] acc,
                                                  input logic fold_msb);
        logic [ACC_W-1:0] f;
        f = fold_msb ? ~acc : acc;
        return {f[ACC_W-2 -: OUT_W-1], 1'b0};
    endfunction

    function automatic logic [OUT_W-1:0] pulse_mask(input logic [ACC_W-1:0] acc,
                                                    input logic [PW_W-1:0] pw);
        return (acc[ACC_W-1 -: OUT_W] >= pw) ? {OUT_W{1'b1}} : {OUT_W{1'b0}};
    endfunction

endpackage

// File: rtl/osc_regs.sv
module osc_regs
    import tone_osc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [FREQ_W-1:0] freq_q,
    output logic [PW_W-1:0]   pw_q,
    output ctrl_t             ctrl_q,
    output logic              test_next
);

    logic [FREQ_W-1:0] freq_d;
    logic [PW_W-1:0]   pw_d;
    ctrl_t             ctrl_d;

    always_comb begin
        freq_d = freq_q;
        pw_d   = pw_q;
        ctrl_d = ctrl_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_FREQ_LO: freq_d[BYTE_W-1:0] = wr_data;
                SEL_FREQ_HI: freq_d[FREQ_W-1:BYTE_W] = wr_data[FREQ_W-BYTE_W-1:0];
                SEL_PW_LO:   pw_d[BYTE_W-1:0] = wr_data;
                SEL_PW_HI:   pw_d[PW_W-1:BYTE_W] = wr_data[PW_W-BYTE_W-1:0];
                SEL_CTRL:    ctrl_d = ctrl_t'(wr_data);
                default: ;
            endcase
        end
    end

    assign test_next = ctrl_d.test;

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q <= '0;
            pw_q   <= '0;
            ctrl_q <= '0;
        end else begin
            freq_q <= freq_d;
            pw_q   <= pw_d;
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/osc_phase.sv
module osc_phase
    import tone_osc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              test_now,
    input  logic              sync_en,
    input  logic              sync_src,
    input  logic [FREQ_W-1:0] freq,
    output logic [ACC_W-1:0]  acc_q
);

    localparam int PAD_W = ACC_W - FREQ_W;

    logic [ACC_W-1:0] acc_r = ACC_POWERUP;
    logic             sync_prev_q;
    logic             sync_hit;
    logic [ACC_W-1:0] freq_ext;

    assign freq_ext = {{PAD_W{1'b0}}, freq};
    assign sync_hit = sync_en & sync_src & ~sync_prev_q;
    assign acc_q    = acc_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_prev_q <= 1'b0;
        end else begin
            sync_prev_q <= sync_src;
        end
    end

    // Phase is deliberately outside the reset domain: it holds while rst is high.
    always_ff @(posedge clk) begin
        if (!rst) begin
            if (test_now || sync_hit) begin
                acc_r <= '0;
            end else begin
                acc_r <= acc_r + freq_ext;
            end
        end
    end

    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (!test_now && !sync_hit) |=> acc_r == $past(acc_r) + $past(freq_ext));

    p_test_clear_r8: assert property (@(posedge clk) disable iff (rst)
        test_now |=> acc_r == '0);

    p_sync_clear_r10: assert property (@(posedge clk) disable iff (rst)
        sync_hit |=> acc_r == '0);

endmodule

// File: rtl/osc_shaper.sv
module osc_shaper
    import tone_osc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc,
    input  logic [PW_W-1:0]  pw,
    input  ctrl_t            ctrl,
    input  logic             ring_src,
    output logic [OUT_W-1:0] wave
);

    logic             fold_msb;
    logic [OUT_W-1:0] saw_v;
    logic [OUT_W-1:0] tri_v;
    logic [OUT_W-1:0] pul_v;
    logic [OUT_W-1:0] mix;
    logic             any_sel;
    logic             unused_bits;

    assign fold_msb = acc[ACC_W-1] ^ (ctrl.ring & ~ctrl.saw_sel & ring_src);
    assign saw_v    = acc[ACC_W-1 -: OUT_W];
    assign tri_v    = tri_fold(acc, fold_msb);
    assign pul_v    = ctrl.test ? {OUT_W{1'b1}} : pulse_mask(acc, pw);
    assign any_sel  = ctrl.tri_sel | ctrl.saw_sel | ctrl.pulse_sel;

    always_comb begin
        mix = {OUT_W{1'b1}};
        if (ctrl.tri_sel)   mix = mix & tri_v;
        if (ctrl.saw_sel)   mix = mix & saw_v;
        if (ctrl.pulse_sel) mix = mix & pul_v;
        wave = any_sel ? mix : '0;
    end

    assign unused_bits = ctrl.spare ^ ctrl.noise_sel ^ ctrl.sync ^ (^acc[ACC_W-OUT_W-1:0]);

    p_tri_lsb_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl.tri_sel |-> wave[0] == 1'b0);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.tri_sel || ctrl.saw_sel || ctrl.pulse_sel) |-> wave == '0);

    p_test_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.test && ctrl.pulse_sel && !ctrl.tri_sel && !ctrl.saw_sel) |-> wave == {OUT_W{1'b1}});

endmodule

// File: rtl/tone_osc.sv
module tone_osc
    import tone_osc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        ring_src,
    input  logic        sync_src,
    output logic [23:0] acc_out,
    output logic [11:0] wave_out
);

    logic [FREQ_W-1:0] freq_q;
    logic [PW_W-1:0]   pw_q;
    ctrl_t             ctrl_q;
    logic              test_next;
    logic [ACC_W-1:0]  acc_q;

    osc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .freq_q    (freq_q),
        .pw_q      (pw_q),
        .ctrl_q    (ctrl_q),
        .test_next (test_next)
    );

    osc_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .test_now (test_next),
        .sync_en  (ctrl_q.sync),
        .sync_src (sync_src),
        .freq     (freq_q),
        .acc_q    (acc_q)
    );

    osc_shaper u_shaper (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc_q),
        .pw       (pw_q),
        .ctrl     (ctrl_q),
        .ring_src (ring_src),
        .wave     (wave_out)
    );

    assign acc_out = acc_q;

endmodule

// File: tb/tb_tone_osc.sv
module tb_tone_osc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        ring_src = 1'b0;
    logic        sync_src = 1'b0;
    logic [23:0] acc_out;
    logic [11:0] wave_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tone_osc dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ring_src(ring_src), .sync_src(sync_src), .acc_out(acc_out), .wave_out(wave_out)
    );

    // Reference model built from the requirements
    logic [23:0] m_acc = 24'h555555;
    logic [15:0] m_freq = '0;
    logic [11:0] m_pw = '0;
    logic [7:0]  m_ctrl = '0;
    logic        m_sprev = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_freq <= '0; m_pw <= '0; m_ctrl <= '0; m_sprev <= 1'b0;
        end else begin
            logic tst;
            logic hit;
            tst = (wr_en && wr_sel == 3'd4) ? wr_data[3] : m_ctrl[3];
            hit = m_ctrl[1] && sync_src && !m_sprev;
            m_acc <= (tst || hit) ? 24'd0 : m_acc + {8'd0, m_freq};
            m_sprev <= sync_src;
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_freq[7:0] <= wr_data;
                    3'd1: m_freq[15:8] <= wr_data;
                    3'd2: m_pw[7:0] <= wr_data;
                    3'd3: m_pw[11:8] <= wr_data[3:0];
                    3'd4: m_ctrl <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [11:0] model_wave();
        logic [11:0] saw, tri_w, pul, o;
        logic msb;
        logic [23:0] f;
        saw = m_acc[23:12];
        msb = m_acc[23] ^ (m_ctrl[2] && !m_ctrl[5] && ring_src);
        f = msb ? ~m_acc : m_acc;
        tri_w = (f >> 11) & 12'hFFE;
        pul = m_ctrl[3] ? 12'hFFF : ((m_acc[23:12] >= m_pw) ? 12'hFFF : 12'h000);
        o = 12'hFFF;
        if (m_ctrl[4]) o = o & tri_w;
        if (m_ctrl[5]) o = o & saw;
        if (m_ctrl[6]) o = o & pul;
        if (m_ctrl[6:4] == 3'b000) o = 12'h000;
        return o;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] freq;
        logic [11:0] pw;
        logic [15:0] cyc;
        logic        ring;
    } vec_t;

    localparam vec_t VECS [0:11] = '{
        '{8'h20, 16'h1234, 12'h000, 16'd37,   1'b0},
        '{8'h10, 16'h2345, 12'h000, 16'd300,  1'b0},
        '{8'h40, 16'h0F00, 12'h800, 16'd1500, 1'b0},
        '{8'h14, 16'h3001, 12'h000, 16'd200,  1'b1},
        '{8'h14, 16'h3001, 12'h000, 16'd200,  1'b0},
        '{8'h34, 16'h3001, 12'h000, 16'd200,  1'b1},
        '{8'h60, 16'h7777, 12'h400, 16'd91,   1'b0},
        '{8'h50, 16'hABCD, 12'hC00, 16'd777,  1'b1},
        '{8'h80, 16'h0F0F, 12'h000, 16'd50,   1'b0},
        '{8'hA0, 16'h0F0F, 12'h000, 16'd50,   1'b0},
        '{8'h70, 16'hFFFF, 12'h100, 16'd5000, 1'b0},
        '{8'h00, 16'h1111, 12'h000, 16'd50,   1'b1}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] snap;
        repeat (3) @(negedge clk);
        chk("R2 power-up phase", acc_out, 32'h555555);
        chk("R1 reset output", wave_out, 0);
        rst = 1'b0;
        @(negedge clk);

        // Vector walk against the reference model
        for (int i = 0; i < 12; i++) begin
            wr(3'd4, 8'h08);
            wr(3'd0, VECS[i].freq[7:0]);
            wr(3'd1, VECS[i].freq[15:8]);
            wr(3'd2, VECS[i].pw[7:0]);
            wr(3'd3, {4'h0, VECS[i].pw[11:8]});
            ring_src = VECS[i].ring;
            wr(3'd4, VECS[i].ctrl);
            for (int c = 0; c < int'(VECS[i].cyc); c++) @(negedge clk);
            chk("R3 phase vs model", acc_out, m_acc);
            chk("R5 R6 R7 R9 R11 wave vs model", wave_out, model_wave());
        end
        ring_src = 1'b0;

        // R2 and R1: phase survives reset, registers clear
        wr(3'd4, 8'h20); wr(3'd0, 8'h21); wr(3'd1, 8'h43);
        repeat (5) @(negedge clk);
        snap = acc_out;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 phase kept in reset", acc_out, snap);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 freq cleared, phase constant", acc_out, snap);
        chk("R1 control cleared, output 0", wave_out, 0);

        // R3 wrap: 512 steps of 0x8000 return to 0
        wr(3'd4, 8'h08); wr(3'd0, 8'h00); wr(3'd1, 8'h80);
        wr(3'd4, 8'h20);
        repeat (511) @(negedge clk);
        chk("R3 wrap modulo 2^24", acc_out, 0);

        // R8 test clears at the write edge and forces pulse
        repeat (3) @(negedge clk);
        wr(3'd3, 8'h0F); wr(3'd2, 8'hFF);
        wr(3'd4, 8'h48);
        chk("R8 cleared at write edge", acc_out, 0);
        repeat (5) @(negedge clk);
        chk("R8 held at 0", acc_out, 0);
        chk("R8 pulse forced high", wave_out, 12'hFFF);

        // R7 / R4: pulse re-evaluated on width writes, upper nibble masked
        wr(3'd0, 8'h00); wr(3'd1, 8'h10);
        wr(3'd4, 8'h40);
        wr(3'd1, 8'h00);
        chk("R3 frozen phase", acc_out, 24'h002000);
        wr(3'd3, 8'h00); wr(3'd2, 8'h02);
        chk("R7 equal compares high", wave_out, 12'hFFF);
        wr(3'd2, 8'h03);
        chk("R7 above phase goes low", wave_out, 12'h000);
        wr(3'd3, 8'hF0);
        chk("R4 upper nibble of width ignored", wave_out, 12'h000);
        wr(3'd2, 8'h00);
        chk("R7 width zero high", wave_out, 12'hFFF);

        // R9 ring modulation, phase 0x002000
        wr(3'd4, 8'h14);
        ring_src = 1'b1;
        @(negedge clk);
        chk("R9 ring flips fold", wave_out, 12'hFFA);
        ring_src = 1'b0;
        @(negedge clk);
        chk("R6 triangle plain", wave_out, 12'h004);
        wr(3'd4, 8'h34);
        ring_src = 1'b1;
        @(negedge clk);
        chk("R9 ring ignored with sawtooth", wave_out, 12'h000);
        ring_src = 1'b0;

        // R10 sync
        wr(3'd4, 8'h22); wr(3'd0, 8'h00); wr(3'd1, 8'h01);
        repeat (3) @(negedge clk);
        sync_src = 1'b1;
        @(negedge clk);
        chk("R10 sync rise clears", acc_out, 0);
        @(negedge clk);
        chk("R10 level does not clear", acc_out, 24'h000100);
        sync_src = 1'b0;
        wr(3'd4, 8'h20);
        repeat (2) @(negedge clk);
        snap = acc_out;
        sync_src = 1'b1;
        @(negedge clk);
        chk("R10 ignored without sync bit", acc_out, snap + 24'h000100);
        sync_src = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule